// File: doc/BRIEF.md
# Block-Sequence-Number Sync Interval Regenerator

This block sits in a block-framed streaming path. Every block carries a sequence number, start and end markers, a valid flag and data. While the output is enabled, blocks pass through unchanged with one clock of latency. The one exception is the sync marker. The input sync is dropped, and a new sync is placed on block boundaries at a programmable interval that is counted in samples. Because the interval is counted in samples, it may be a fractional number of blocks.

Control works as follows:
- Software raises the enable level and strobes an event together with a start sequence number and an interval.
- Output begins at the first block whose number reaches the start value, and it carries a start pulse and a sync.
- Lowering the enable stops the output only at a block boundary.

The sync schedule is computed from the sequence number and not from a count of received blocks. Losing input blocks therefore does not shift later syncs. Monitors report the most recent input sequence number, the sequence number at the most recent input sync, and the sequence number at the most recent output sync.

Top module: `bsn_sync_regen`

## Requirements
- R1: After reset, every output is zero, including all monitors and `out_en`.
- R2: While a block is forwarded, `out_bsn`, `out_sop`, `out_eop`, `out_valid` and `out_data` equal the inputs of the previous cycle, and each forwarded block has all BLK_SZ samples.
- R3: When `out_en` is low, `out_valid`, `out_sop`, `out_eop` and `out_sync` are low.
- R4: An event strobe with enable high arms a start only if the start number is strictly greater than the current input number. The current input number is the number of a valid sop in the same cycle, or else the last one seen. Output then begins with the first valid input block whose number is at least the start number, and `out_en` rises in the same cycle as that block's output sop.
- R5: An event strobe with enable high and a start number that is not in the future is ignored: output that is stopped stays stopped.
- R6: `out_start` is a one-cycle pulse. It sits on the output sop of the first block after a start, and `out_sync` is high in that same cycle.
- R7: When enable is low, no new block is forwarded. A block already in flight completes, and `out_en` falls in the cycle after its output eop (or in the next cycle if no block is in flight).
- R8: Let block k = bsn − start occupy samples k·BLK_SZ … k·BLK_SZ+BLK_SZ−1, and let I be the interval, raised to BLK_SZ if it is smaller. The interval is latched at start. A forwarded block carries sync on its sop exactly when its last sample is at or beyond a multiple of I that no earlier forwarded block of the same run reached. Sync never appears off a sop.
- R9: After lost input blocks (no sop, eop, valid or sync), the next sync falls on the first forwarded block whose range reaches the next multiple of I, as given by R8.
- R10: A new armed start while output runs keeps blocks flowing on the old schedule until the new start block. That block then gets `out_start` and a sync, and the schedule is rebased on the new start and interval.
- R11: `mon_in_bsn` holds the number of the latest valid input sop, and `mon_in_sync_bsn` holds the number of the latest valid input sop that had sync.
- R12: `mon_out_sync_bsn` equals `out_bsn` in every cycle with `out_sync` and holds that value afterwards.
- R13: Start, stop and sync placement do not depend on the number of idle cycles between input blocks (0 to 5 tested).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Output enable level |
| en_evt_i | input | 1 | One-cycle strobe that arms a start when en_i is high |
| start_bsn_i | input | BSN_W | Start sequence number sampled with the strobe |
| intv_i | input | INTV_W | Sync interval in samples, latched at start |
| in_sync | input | 1 | Input sync marker (dropped) |
| in_sop | input | 1 | Input start of block |
| in_eop | input | 1 | Input end of block |
| in_valid | input | 1 | Input sample valid |
| in_bsn | input | BSN_W | Input block sequence number |
| in_data | input | DATA_W | Input sample |
| out_sync | output | 1 | Regenerated sync, on sop only |
| out_sop | output | 1 | Output start of block |
| out_eop | output | 1 | Output end of block |
| out_valid | output | 1 | Output sample valid |
| out_bsn | output | BSN_W | Output block sequence number |
| out_data | output | DATA_W | Output sample |
| out_start | output | 1 | Pulse on first block after a start |
| out_en | output | 1 | Output enable state |
| mon_in_bsn | output | BSN_W | Number of latest input block |
| mon_in_sync_bsn | output | BSN_W | Number of latest input block with sync |
| mon_out_sync_bsn | output | BSN_W | Number of latest output sync block |

## Verification
A wrong next-sync offset does not show at the ports until the next forwarded sop, and that can be several blocks later. The bench therefore recomputes the expected sync for every output block from the sequence number, which catches an offset error at the first block where it matters. A stuck pending-start flag shows as a missing or unexpected `out_start` at the start block. A wrong in-block flag shows as `out_en` falling mid-block, or as a truncated block in the cycle after the enable drops. Lost-block runs are checked against the sequence-number-based placement, so a design that counts received blocks fails on the first sync after the gap.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ARM   = 2'd1,
    EV_STALE = 2'd2,
    EV_OFF   = 2'd3
  } ev_kind_t;

  function automatic ev_kind_t ev_classify(input logic en, input logic evt, input logic ahead);
    if (!evt)       return EV_NONE;
    else if (!en)   return EV_OFF;
    else if (ahead) return EV_ARM;
    else            return EV_STALE;
  endfunction

endpackage

// File: rtl/bsr_monitor.sv
module bsr_monitor #(
  parameter int BSN_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop_ok,
  input  logic             in_sync,
  input  logic [BSN_W-1:0] in_bsn,
  output logic [BSN_W-1:0] cur_bsn_o,
  output logic [BSN_W-1:0] sync_bsn_o
);
  logic cur_ce, sync_ce;

  always_comb begin
    cur_ce  = sop_ok;
    sync_ce = sop_ok & in_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bsn_o  <= '0;
      sync_bsn_o <= '0;
    end else begin
      if (cur_ce)  cur_bsn_o  <= in_bsn;
      if (sync_ce) sync_bsn_o <= in_bsn;
    end
  end
endmodule

// File: rtl/bsr_sched.sv
module bsr_sched
  import bsr_pkg::*;
#(
  parameter int BSN_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic [BSN_W-1:0] start_i,
  input  logic [BSN_W-1:0] cur_now,
  input  logic             sop_ok,
  input  logic [BSN_W-1:0] in_bsn,
  output logic             hit_o,
  output logic [BSN_W-1:0] start_o
);
  logic             pend_q, pend_n;
  logic [BSN_W-1:0] start_q, start_n;
  ev_kind_t         kind;

  always_comb begin
    kind    = ev_classify(en_i, evt_i, start_i > cur_now);
    hit_o   = pend_q & en_i & sop_ok & (in_bsn >= start_q);
    start_o = start_q;
    start_n = start_q;
    pend_n  = pend_q;
    if (!en_i) begin
      pend_n = 1'b0;
    end else if (kind == EV_ARM) begin
      pend_n  = 1'b1;
      start_n = start_i;
    end else if (hit_o) begin
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      start_q <= '0;
    end else begin
      pend_q <= pend_n;
      if (kind == EV_ARM) start_q <= start_n;
    end
  end
endmodule

// File: rtl/bsr_syncpos.sv
module bsr_syncpos #(
  parameter int BSN_W  = 31,
  parameter int BLK_SZ = 10,
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_pass,
  input  logic              hit,
  input  logic [BSN_W-1:0]  in_bsn,
  input  logic [BSN_W-1:0]  start_bsn,
  input  logic [INTV_W-1:0] intv_i,
  output logic              sync_o
);
  localparam int OFF_W = BSN_W + $clog2(BLK_SZ) + 1;

  logic [BSN_W-1:0]  base_q, base_eff, k;
  logic [INTV_W-1:0] intv_q, intv_c, intv_eff;
  logic [OFF_W-1:0]  next_q, next_eff, next_n, last_off, step;

  always_comb begin
    intv_c   = (intv_i < INTV_W'(BLK_SZ)) ? INTV_W'(BLK_SZ) : intv_i;
    base_eff = hit ? start_bsn : base_q;
    intv_eff = hit ? intv_c : intv_q;
    next_eff = hit ? '0 : next_q;
    k        = in_bsn - base_eff;
    last_off = OFF_W'(k) * OFF_W'(BLK_SZ) + OFF_W'(BLK_SZ - 1);
    step     = OFF_W'(intv_eff);
    sync_o   = sop_pass & (next_eff <= last_off);
    next_n   = (last_off / step + OFF_W'(1)) * step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      intv_q <= INTV_W'(BLK_SZ);
      next_q <= '0;
    end else begin
      if (hit) begin
        base_q <= start_bsn;
        intv_q <= intv_c;
      end
      if (sync_o) next_q <= next_n;
    end
  end
endmodule

// File: rtl/bsn_sync_regen.sv
module bsn_sync_regen #(
  parameter int BSN_W  = 31,
  parameter int BLK_SZ = 10,
  parameter int DATA_W = 16,
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              en_evt_i,
  input  logic [BSN_W-1:0]  start_bsn_i,
  input  logic [INTV_W-1:0] intv_i,
  input  logic              in_sync,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_valid,
  input  logic [BSN_W-1:0]  in_bsn,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_sync,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_valid,
  output logic [BSN_W-1:0]  out_bsn,
  output logic [DATA_W-1:0] out_data,
  output logic              out_start,
  output logic              out_en,
  output logic [BSN_W-1:0]  mon_in_bsn,
  output logic [BSN_W-1:0]  mon_in_sync_bsn,
  output logic [BSN_W-1:0]  mon_out_sync_bsn
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic             sop_ok, hit, sync_c, pass_sop, fwd;
  logic             blk_q, blk_n, run_q, run_n;
  logic [BSN_W-1:0] cur_now, start_q;

  // reset: asynchronous assert, two-stage synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign sop_ok  = in_sop & in_valid;
  assign cur_now = sop_ok ? in_bsn : mon_in_bsn;

  bsr_monitor #(.BSN_W(BSN_W)) u_mon (
    .clk(clk), .rst_n(rst_int_n), .sop_ok(sop_ok), .in_sync(in_sync),
    .in_bsn(in_bsn), .cur_bsn_o(mon_in_bsn), .sync_bsn_o(mon_in_sync_bsn)
  );

  bsr_sched #(.BSN_W(BSN_W)) u_sched (
    .clk(clk), .rst_n(rst_int_n), .en_i(en_i), .evt_i(en_evt_i),
    .start_i(start_bsn_i), .cur_now(cur_now), .sop_ok(sop_ok),
    .in_bsn(in_bsn), .hit_o(hit), .start_o(start_q)
  );

  bsr_syncpos #(.BSN_W(BSN_W), .BLK_SZ(BLK_SZ), .INTV_W(INTV_W)) u_pos (
    .clk(clk), .rst_n(rst_int_n), .sop_pass(pass_sop), .hit(hit),
    .in_bsn(in_bsn), .start_bsn(start_q), .intv_i(intv_i), .sync_o(sync_c)
  );

  // block gate: decide at sop, hold for the whole block
  always_comb begin
    pass_sop = sop_ok & (hit | (run_q & en_i));
    fwd      = sop_ok ? pass_sop : blk_q;
    if (sop_ok)                 blk_n = pass_sop & ~in_eop;
    else if (in_valid & in_eop) blk_n = 1'b0;
    else                        blk_n = blk_q;
    if (pass_sop)               run_n = 1'b1;
    else if (sop_ok)            run_n = 1'b0;
    else if (!en_i && !blk_q)   run_n = 1'b0;
    else                        run_n = run_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      blk_q            <= 1'b0;
      run_q            <= 1'b0;
      out_sync         <= 1'b0;
      out_sop          <= 1'b0;
      out_eop          <= 1'b0;
      out_valid        <= 1'b0;
      out_bsn          <= '0;
      out_data         <= '0;
      out_start        <= 1'b0;
      mon_out_sync_bsn <= '0;
    end else begin
      blk_q     <= blk_n;
      run_q     <= run_n;
      out_sync  <= sync_c;
      out_sop   <= pass_sop;
      out_eop   <= fwd & in_valid & in_eop;
      out_valid <= fwd & in_valid;
      out_bsn   <= fwd ? in_bsn : '0;
      out_data  <= fwd ? in_data : '0;
      out_start <= hit;
      if (sync_c) mon_out_sync_bsn <= in_bsn;
    end
  end

  assign out_en = run_q;
endmodule

// File: rtl/bsr_chk.sv
module bsr_chk #(
  parameter int BSN_W  = 31,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] in_data,
  input logic              out_sync,
  input logic              out_sop,
  input logic              out_eop,
  input logic              out_valid,
  input logic [BSN_W-1:0]  out_bsn,
  input logic [DATA_W-1:0] out_data,
  input logic              out_start,
  input logic              out_en,
  input logic [BSN_W-1:0]  mon_out_sync_bsn
);
  logic in_blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  in_blk_q <= 1'b0;
    else if (out_eop)            in_blk_q <= 1'b0;
    else if (out_sop)            in_blk_q <= 1'b1;
  end

  a_r6_start_marks_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> (out_sop && out_sync && out_en));
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |=> !out_start);
  a_r4_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> out_start);
  a_r7_whole_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en) |-> !in_blk_q);
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!out_valid && !out_sop && !out_eop && !out_sync));
  a_r8_sync_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_sop);
  a_r12_sync_bsn_mon: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> (mon_out_sync_bsn == out_bsn));
  a_r2_data_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data == $past(in_data)));
endmodule

bind bsn_sync_regen bsr_chk #(.BSN_W(BSN_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .out_sync(out_sync),
  .out_sop(out_sop), .out_eop(out_eop), .out_valid(out_valid),
  .out_bsn(out_bsn), .out_data(out_data), .out_start(out_start),
  .out_en(out_en), .mon_out_sync_bsn(mon_out_sync_bsn)
);

// File: tb/sim_bsn_sync_regen.sv
`timescale 1ns/1ps
module sim_bsn_sync_regen;
  localparam int BSN_W = 31, B = 10, DW = 16, IW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, en_i, en_evt_i, in_sync, in_sop, in_eop, in_valid;
  logic [BSN_W-1:0] start_bsn_i, in_bsn;
  logic [IW-1:0] intv_i;
  logic [DW-1:0] in_data;
  logic out_sync, out_sop, out_eop, out_valid, out_start, out_en;
  logic [BSN_W-1:0] out_bsn, mon_in_bsn, mon_in_sync_bsn, mon_out_sync_bsn;
  logic [DW-1:0] out_data;

  bsn_sync_regen #(.BSN_W(BSN_W), .BLK_SZ(B), .DATA_W(DW), .INTV_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .en_evt_i(en_evt_i),
    .start_bsn_i(start_bsn_i), .intv_i(intv_i), .in_sync(in_sync),
    .in_sop(in_sop), .in_eop(in_eop), .in_valid(in_valid), .in_bsn(in_bsn),
    .in_data(in_data), .out_sync(out_sync), .out_sop(out_sop),
    .out_eop(out_eop), .out_valid(out_valid), .out_bsn(out_bsn),
    .out_data(out_data), .out_start(out_start), .out_en(out_en),
    .mon_in_bsn(mon_in_bsn), .mon_in_sync_bsn(mon_in_sync_bsn),
    .mon_out_sync_bsn(mon_out_sync_bsn)
  );

  int total = 0, bad = 0;
  bit done = 0;
  bit mon_on = 0;
  int last_sent = -1;

  // bench model of the expected output stream
  int  nblk = 0, nstart = 0, idx = 0, blk_bsn = 0, last_out_bsn = -1;
  int  cur_start = 0, cur_iv = B, pend_start = 0, pend_iv = B;
  bit  exp_pending = 0, prev_en = 0;
  longint prev_end = -1;

  function automatic logic [DW-1:0] mk(input int bsn, input int i);
    return DW'(bsn * 16 + i);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_beat();
    in_valid = 0; in_sop = 0; in_eop = 0; in_sync = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; idle_beat();
    end
  endtask

  task automatic send_blk(input int bsn, input int gap, input bit lose, input int drop_at);
    for (int i = 0; i < B; i++) begin
      @(posedge clk); #1;
      in_valid = !lose;
      in_sop   = !lose && (i == 0);
      in_eop   = !lose && (i == B - 1);
      in_sync  = !lose && (i == 0) && (bsn % 17 == 0);
      in_bsn   = BSN_W'(bsn);
      in_data  = mk(bsn, i);
      if (i == drop_at) en_i = 0;
    end
    if (!lose) last_sent = bsn;
    idle(gap);
  endtask

  task automatic arm(input int start, input int iv);
    @(posedge clk); #1;
    idle_beat();
    en_i = 1; en_evt_i = 1; start_bsn_i = BSN_W'(start); intv_i = IW'(iv);
    if (start > last_sent) begin
      exp_pending = 1; pend_start = start; pend_iv = (iv < B) ? B : iv;
    end
    @(posedge clk); #1;
    en_evt_i = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on && !done) begin
      if (out_valid) chk(out_en, "R3 valid while disabled", out_en, 1);
      if (prev_en && !out_en) chk(idx == 0, "R7 stop inside block", idx, 0);
      if (out_sop) begin
        chk(idx == 0, "R7 previous block truncated", idx, 0);
        if (out_start) begin
          chk(exp_pending, "R6 unexpected out_start", out_start, exp_pending);
          chk(int'(out_bsn) == pend_start, "R4 first block bsn", out_bsn, pend_start);
          chk(out_sync, "R6 sync at start", out_sync, 1);
          cur_start = pend_start; cur_iv = pend_iv; prev_end = -1;
          exp_pending = 0; nstart++;
        end
        begin
          longint k, e;
          bit es;
          k  = longint'(int'(out_bsn) - cur_start);
          e  = k * B + B - 1;
          es = (prev_end < 0) || (e / cur_iv > prev_end / cur_iv);
          chk(out_sync == es, "R8 R9 sync placement", out_sync, es);
          prev_end = e;
        end
        if (out_sync) chk(mon_out_sync_bsn == out_bsn, "R12 output sync monitor", mon_out_sync_bsn, out_bsn);
        blk_bsn = int'(out_bsn); last_out_bsn = blk_bsn; nblk++;
      end
      if (out_valid) begin
        chk(out_data == mk(blk_bsn, idx) && int'(out_bsn) == blk_bsn, "R2 forwarded sample",
            out_data, mk(blk_bsn, idx));
        idx++;
        if (out_eop) begin
          chk(idx == B, "R2 block length", idx, B);
          idx = 0;
        end
      end
      prev_en = out_en;
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int n0, s0, b;
    rst_n = 0; en_i = 0; en_evt_i = 0; start_bsn_i = '0; intv_i = IW'(B);
    in_bsn = '0; in_data = '0; idle_beat();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!out_en && !out_valid && !out_start && !out_sync && out_bsn == 0 &&
        mon_in_bsn == 0 && mon_in_sync_bsn == 0 && mon_out_sync_bsn == 0,
        "R1 reset outputs", out_en, 0);
    @(posedge clk); #1; rst_n = 1;
    idle(5);
    @(negedge clk);
    chk(!out_en && !out_valid && mon_out_sync_bsn == 0, "R1 after release", out_en, 0);
    mon_on = 1;

    // disabled stream
    for (int i = 0; i <= 4; i++) send_blk(i, 3, 0, -1);
    idle(2);
    chk(nblk == 0, "R3 nothing while disabled", nblk, 0);
    chk(mon_in_bsn == 4, "R11 current bsn", mon_in_bsn, 4);
    chk(mon_in_sync_bsn == 0, "R11 sync bsn", mon_in_sync_bsn, 0);

    // start in future, fractional interval, stop mid-block
    arm(10, 45);
    for (int i = 5; i <= 39; i++) send_blk(i, 3, 0, -1);
    send_blk(40, 3, 0, 5);
    idle(3);
    chk(nblk == 31, "R4 blocks from start", nblk, 31);
    chk(last_out_bsn == 40, "R7 in-flight block completes", last_out_bsn, 40);
    chk(!out_en, "R7 enable low after stop", out_en, 0);
    chk(mon_in_sync_bsn == 34, "R11 latest input sync", mon_in_sync_bsn, 34);

    // start in past is ignored
    n0 = nblk;
    arm(20, 45);
    for (int i = 41; i <= 48; i++) send_blk(i, 3, 0, -1);
    idle(2);
    chk(nblk == n0, "R5 stale start ignored", nblk - n0, 0);
    chk(!out_en, "R5 output stays off", out_en, 0);

    // zero gaps, whole-block interval
    n0 = nblk;
    arm(55, 30);
    for (int i = 49; i <= 70; i++) send_blk(i, 0, 0, -1);
    idle(2);
    chk(nblk - n0 == 16, "R13 zero-gap run", nblk - n0, 16);

    // reschedule while running
    n0 = nblk; s0 = nstart;
    arm(75, 45);
    for (int i = 71; i <= 95; i++) send_blk(i, 5, 0, -1);
    idle(2);
    chk(nblk - n0 == 25, "R10 flow continues", nblk - n0, 25);
    chk(nstart - s0 == 1, "R10 fresh start pulse", nstart - s0, 1);

    // lost blocks
    for (int i = 96; i <= 150; i++) send_blk(i, 2, 1, -1);
    for (int i = 151; i <= 163; i++) send_blk(i, 2, 0, -1);
    idle(3);
    chk(mon_out_sync_bsn == 160, "R9 sync after loss", mon_out_sync_bsn, 160);
    en_i = 0;
    idle(3);
    chk(!out_en, "R7 idle stop", out_en, 0);

    // interval sweep with varied gaps
    b = 164;
    foreach (intv_sweep[j]) begin
      n0 = nblk;
      arm(b + 2, intv_sweep[j]);
      for (int i = 0; i < 20; i++) send_blk(b + i, j % 6, 0, -1);
      en_i = 0;
      idle(4);
      chk(nblk - n0 == 18, "R8 R13 sweep block count", nblk - n0, 18);
      b += 20;
    end
    idle(5);
    finish_up();
  end

  int intv_sweep[7] = '{5, 10, 15, 20, 25, 45, 100};
endmodule